// File: doc/BRIEF.md
# Hardware Store Request Sequencer

This block runs the store handshake of a nonvolatile static RAM over a single open-drain line. That one line is used in both directions. When a host asks for a store, the sequencer pulls the line low for a fixed number of cycles, which starts a nonvolatile store. It then releases the line and waits for the device to pull it low. A low line means the store is in progress. When the device releases the line, the sequencer holds memory access off for a fixed recovery time. It then raises a one-cycle completion pulse and allows access again.

The device can also pull the line low without a host request, for example when it stores on power loss. The sequencer treats such a pulse like a host-started store: access is blocked, the same recovery follows, and the same completion pulse is raised. If the device never answers a host request, a timeout raises a one-cycle error pulse and the sequencer returns to idle. A write that is already being held by chip enable and write enable when a store finishes stays suppressed until one of those two strobes falls again.

Top module: `hwstore_sequencer`

## Requirements
- R1: After reset the line is released (`busyLineDriveLow` = 0), `accessAllowed` = 1, `writeAllowed` = 1, and `storeDone` = `storeError` = 0.
- R2: A `storeReq` sampled high while idle drives `busyLineDriveLow` high for exactly PULSE_CYC cycles, starting in the next cycle. `accessAllowed` is 0 whenever the line is driven.
- R3: The line is sampled through a SYNC_STAGES-flop synchronizer. For SYNC_STAGES cycles after the drive is released, a stale low produced by the sequencer's own pulse is not taken as busy.
- R4: Call the edge at which the drive is released edge 0. If the device has not driven the line low early enough to be detected by edge TIMEOUT_CYC, `storeError` goes high for exactly one cycle after that edge. The sequencer then returns to idle with `accessAllowed` = 1 and raises no `storeDone`.
- R5: With the same edge numbering, a device that drives the line low from edge D+1 through edge D+H (H ≥ 1, D ≤ TIMEOUT_CYC−3) produces `storeDone` after edge D+H+3+RECOVER_CYC. `accessAllowed` stays 0 until that edge.
- R6: If the line goes low again during recovery, the sequencer returns to busy. Recovery is then timed from the last release, so `storeDone` follows the first high-sampling edge after the final release by RECOVER_CYC+2 edges.
- R7: A low on the line while idle, with no request, is treated as a device-initiated store. `accessAllowed` falls after the third edge that samples the line low and is still high after the second. The sequencer never drives the line during such a store, and the store ends with the same recovery and `storeDone`.
- R8: `storeReq` is ignored while a store or recovery is under way: no drive pulse follows it once the sequencer is idle again.
- R9: `storeDone` lasts exactly one cycle, and `accessAllowed` is 1 during it. `accessAllowed` rises only together with `storeDone` or `storeError`.
- R10: If `chipEnN` and `writeEnN` are both 0 at the edge that ends recovery, `writeAllowed` stays 0 (while `accessAllowed` is 1) until an edge samples a falling transition on either strobe. Otherwise `writeAllowed` equals `accessAllowed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| storeReq | input | 1 | Host request to start a nonvolatile store |
| busyLineIn | input | 1 | Level sensed on the open-drain store/busy line |
| busyLineDriveLow | output | 1 | 1 enables the pull-down on the line; 0 releases it |
| chipEnN | input | 1 | Memory chip enable, active low |
| writeEnN | input | 1 | Memory write enable, active low |
| accessAllowed | output | 1 | Memory access may proceed |
| writeAllowed | output | 1 | Memory writes may proceed |
| storeDone | output | 1 | One-cycle pulse when a store and its recovery are complete |
| storeError | output | 1 | One-cycle pulse when the device fails to answer a request |

## Verification
Host-started stores are swept over every device answer delay from zero up to the last delay that can still be detected. For each delay, several busy lengths are tried, which separates an off-by-one in the synchronizer, the blanking window or the recovery counter. An answer delay one cycle too late, and no answer at all, confirm that the timeout fires at its exact edge. The late answer also confirms that the device pulse is then picked up as a device-initiated store. Device-initiated pulses are tried with and without a second low during recovery, a request is raised mid-store to show it is dropped, and stores ending with both strobes low or with chip enable high tell the write suppression apart from plain access gating.

// File: rtl/hwstore_pkg.sv
package hwstore_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_WAIT,
    ST_BUSY,
    ST_RECOVER,
    ST_DONE
  } seqState_t;

  typedef struct packed {
    logic driveLow;    // pull the shared line low
    logic clrCnt;      // restart the interval counter
    logic timeout;     // no busy answer in time
    logic armWrBlock;  // recovery finished: capture write-in-flight
  } seqStrobe_t;
endpackage

// File: rtl/hwstore_datapath.sv
module hwstore_datapath
  import hwstore_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 40,
  parameter int RECOVER_CYC = 88,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  input  logic       lineIn,
  input  logic       chipEnN,
  input  logic       writeEnN,
  output logic       lineLow,
  output logic       pulseEnd,
  output logic       blankOver,
  output logic       timeoutHit,
  output logic       recoverEnd,
  output logic       writeBlocked,
  output logic       errPulse
);
  localparam int CNT_MAX_A = (PULSE_CYC > TIMEOUT_CYC) ? PULSE_CYC : TIMEOUT_CYC;
  localparam int CNT_MAX   = (CNT_MAX_A > RECOVER_CYC) ? CNT_MAX_A : RECOVER_CYC;
  localparam int CNT_W     = $clog2(CNT_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [CNT_W-1:0]       cnt;
  logic                   prevCe, prevWe, strobeFall;

  // Synchronizer chain for the asynchronous line level
  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) syncQ[s] <= 1'b1;
      else if (s == 0) syncQ[s] <= lineIn;
      else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  assign lineLow = ~syncQ[SYNC_STAGES-1];

  // Shared interval counter, saturating
  always_ff @(posedge clk) begin
    if (!rstN || strobe.clrCnt) cnt <= '0;
    else if (cnt != CNT_W'(CNT_MAX)) cnt <= cnt + 1'b1;
  end

  assign pulseEnd   = (cnt == CNT_W'(PULSE_CYC - 1));
  assign blankOver  = (cnt >= CNT_W'(SYNC_STAGES));
  assign timeoutHit = (cnt == CNT_W'(TIMEOUT_CYC - 1));
  assign recoverEnd = (cnt == CNT_W'(RECOVER_CYC - 1));

  // Write suppression until a fresh strobe edge
  assign strobeFall = (prevCe & ~chipEnN) | (prevWe & ~writeEnN);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCe       <= 1'b1;
      prevWe       <= 1'b1;
      writeBlocked <= 1'b0;
      errPulse     <= 1'b0;
    end else begin
      prevCe   <= chipEnN;
      prevWe   <= writeEnN;
      errPulse <= strobe.timeout;
      if (strobe.armWrBlock) writeBlocked <= ~chipEnN & ~writeEnN;
      else if (strobeFall)   writeBlocked <= 1'b0;
    end
  end
endmodule

// File: rtl/hwstore_control.sv
module hwstore_control
  import hwstore_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       storeReq,
  input  logic       lineLow,
  input  logic       pulseEnd,
  input  logic       blankOver,
  input  logic       timeoutHit,
  input  logic       recoverEnd,
  output seqStrobe_t strobe,
  output seqState_t  state
);
  seqState_t nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (storeReq) begin
          nextState     = ST_PULSE;
          strobe.clrCnt = 1'b1;
        end else if (lineLow) begin
          nextState = ST_BUSY;
        end
      end
      ST_PULSE: begin
        strobe.driveLow = 1'b1;
        if (pulseEnd) begin
          nextState     = ST_WAIT;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_WAIT: begin
        if (blankOver && lineLow) begin
          nextState = ST_BUSY;
        end else if (timeoutHit) begin
          nextState      = ST_IDLE;
          strobe.timeout = 1'b1;
        end
      end
      ST_BUSY: begin
        if (!lineLow) begin
          nextState     = ST_RECOVER;
          strobe.clrCnt = 1'b1;
        end
      end
      ST_RECOVER: begin
        if (lineLow) begin
          nextState = ST_BUSY;
        end else if (recoverEnd) begin
          nextState         = ST_DONE;
          strobe.armWrBlock = 1'b1;
        end
      end
      ST_DONE: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/hwstore_sequencer.sv
module hwstore_sequencer
  import hwstore_pkg::*;
#(
  parameter int PULSE_CYC   = 3,
  parameter int TIMEOUT_CYC = 40,
  parameter int RECOVER_CYC = 88,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic storeReq,
  input  logic busyLineIn,
  output logic busyLineDriveLow,
  input  logic chipEnN,
  input  logic writeEnN,
  output logic accessAllowed,
  output logic writeAllowed,
  output logic storeDone,
  output logic storeError
);
  seqStrobe_t strobe;
  seqState_t  state;
  logic lineLow, pulseEnd, blankOver, timeoutHit, recoverEnd, writeBlocked, errPulse;

  hwstore_control u_ctrl (
    .clk(clk), .rstN(rstN), .storeReq(storeReq), .lineLow(lineLow),
    .pulseEnd(pulseEnd), .blankOver(blankOver), .timeoutHit(timeoutHit),
    .recoverEnd(recoverEnd), .strobe(strobe), .state(state)
  );

  hwstore_datapath #(
    .PULSE_CYC(PULSE_CYC), .TIMEOUT_CYC(TIMEOUT_CYC),
    .RECOVER_CYC(RECOVER_CYC), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIn(busyLineIn),
    .chipEnN(chipEnN), .writeEnN(writeEnN), .lineLow(lineLow),
    .pulseEnd(pulseEnd), .blankOver(blankOver), .timeoutHit(timeoutHit),
    .recoverEnd(recoverEnd), .writeBlocked(writeBlocked), .errPulse(errPulse)
  );

  assign busyLineDriveLow = strobe.driveLow;
  assign storeDone        = (state == ST_DONE);
  assign accessAllowed    = (state == ST_IDLE) || (state == ST_DONE);
  assign writeAllowed     = accessAllowed & ~writeBlocked;
  assign storeError       = errPulse;
endmodule

// File: rtl/hwstore_checker.sv
module hwstore_checker (
  input logic clk,
  input logic rstN,
  input logic storeReq,
  input logic busyLineDriveLow,
  input logic accessAllowed,
  input logic writeAllowed,
  input logic storeDone,
  input logic storeError
);
  assert_drive_blocks_access_R2: assert property (@(posedge clk) disable iff (!rstN)
    busyLineDriveLow |-> !accessAllowed);

  assert_drive_needs_request_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busyLineDriveLow) |-> $past(storeReq));

  assert_error_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    storeError |=> !storeError);

  assert_error_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    storeError |-> (accessAllowed && !storeDone));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    storeDone |=> !storeDone);

  assert_done_access_R9: assert property (@(posedge clk) disable iff (!rstN)
    storeDone |-> accessAllowed);

  assert_access_return_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(accessAllowed) |-> (storeDone || storeError));

  assert_write_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    writeAllowed |-> accessAllowed);
endmodule

bind hwstore_sequencer hwstore_checker u_chk (
  .clk(clk), .rstN(rstN), .storeReq(storeReq), .busyLineDriveLow(busyLineDriveLow),
  .accessAllowed(accessAllowed), .writeAllowed(writeAllowed),
  .storeDone(storeDone), .storeError(storeError)
);

// File: tb/hwstore_sequencer_tb.sv
module hwstore_sequencer_tb;
  localparam int PULSE   = 3;
  localparam int TIMEOUT = 10;
  localparam int RECOVER = 6;
  localparam int SYNC    = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic storeReq = 1'b0;
  logic devLow = 1'b0;
  logic chipEnN = 1'b1;
  logic writeEnN = 1'b1;
  logic busyLineIn, busyLineDriveLow, accessAllowed, writeAllowed, storeDone, storeError;
  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  assign busyLineIn = ~(busyLineDriveLow | devLow);

  hwstore_sequencer #(
    .PULSE_CYC(PULSE), .TIMEOUT_CYC(TIMEOUT), .RECOVER_CYC(RECOVER), .SYNC_STAGES(SYNC)
  ) u_dut (
    .clk(clk), .rstN(rstN), .storeReq(storeReq), .busyLineIn(busyLineIn),
    .busyLineDriveLow(busyLineDriveLow), .chipEnN(chipEnN), .writeEnN(writeEnN),
    .accessAllowed(accessAllowed), .writeAllowed(writeAllowed),
    .storeDone(storeDone), .storeError(storeError)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Host store; k counts edges since the pulse release (k=0 is the negedge after it)
  task automatic hostStore(input int dly, input int hold, input bit respond,
                           output int pulseLen, output int errK, output int doneK,
                           output int accBad);
    pulseLen = 0; errK = -1; doneK = -1; accBad = 0;
    @(negedge clk) storeReq = 1'b1;
    @(negedge clk) storeReq = 1'b0;
    while (busyLineDriveLow && pulseLen < 50) begin
      pulseLen++;
      if (accessAllowed) accBad++;
      @(negedge clk);
    end
    for (int k = 0; k < 80 && doneK < 0; k++) begin
      if (storeError && errK < 0) errK = k;
      if (storeDone) doneK = k;
      else if (accessAllowed && errK < 0) accBad++;
      if (doneK < 0) begin
        devLow = respond && (k >= dly) && (k < dly + hold);
        @(negedge clk);
      end
    end
    devLow = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finishRun();
  end

  initial begin
    int pLen, eK, dK, aBad, expDone, expErr, k0, accAt2, accAt3, drove;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busyLineDriveLow, "R1 drive", busyLineDriveLow, 0);
    check(accessAllowed && writeAllowed, "R1 access", accessAllowed & writeAllowed, 1);
    check(!storeDone && !storeError, "R1 pulses", storeDone | storeError, 0);

    // R2 R3 R4 R5 sweep over answer delay and busy length
    for (int d = 0; d <= TIMEOUT - 2; d++) begin
      for (int h = 1; h <= 4; h++) begin
        hostStore(d, h, 1'b1, pLen, eK, dK, aBad);
        expDone = d + h + 3 + RECOVER;
        expErr  = (d <= TIMEOUT - 3) ? -1 : TIMEOUT;
        check(pLen == PULSE, "R2 pulse length", pLen, PULSE);
        check(aBad == 0, "R5 access held off", aBad, 0);
        check(dK == expDone, "R5 R3 done edge", dK, expDone);
        check(eK == expErr, "R4 error edge", eK, expErr);
        repeat (2) @(negedge clk);
      end
    end

    // R4 device never answers
    hostStore(0, 0, 1'b0, pLen, eK, dK, aBad);
    check(eK == TIMEOUT, "R4 timeout edge", eK, TIMEOUT);
    check(dK == -1, "R4 no done", dK, -1);
    check(accessAllowed, "R4 idle after error", accessAllowed, 1);

    // R7 device-initiated store
    drove = 0;
    @(negedge clk) devLow = 1'b1;
    @(negedge clk); @(negedge clk);
    accAt2 = accessAllowed;
    @(negedge clk);
    accAt3 = accessAllowed;
    check(accAt2 == 1, "R7 access before third edge", accAt2, 1);
    check(accAt3 == 0, "R7 access after third edge", accAt3, 0);
    devLow = 1'b0;
    dK = -1;
    for (int k = 0; k < 40 && dK < 0; k++) begin
      if (storeDone) dK = k;
      if (busyLineDriveLow) drove++;
      if (dK < 0) @(negedge clk);
    end
    check(dK == RECOVER + 3, "R7 done edge", dK, RECOVER + 3);
    check(drove == 0, "R7 line not driven", drove, 0);
    @(negedge clk);
    check(!storeDone, "R9 done single cycle", storeDone, 0);

    // R6 relow during recovery, R8 request ignored mid-store
    repeat (2) @(negedge clk);
    devLow = 1'b1;
    repeat (4) @(negedge clk);
    storeReq = 1'b1;
    @(negedge clk) storeReq = 1'b0;
    devLow = 1'b0;          // first release
    repeat (4) @(negedge clk);
    devLow = 1'b1;          // low again while recovering
    repeat (2) @(negedge clk);
    devLow = 1'b0;          // final release
    dK = -1;
    for (int k = 0; k < 40 && dK < 0; k++) begin
      if (storeDone) dK = k;
      if (dK < 0) @(negedge clk);
    end
    check(dK == RECOVER + 3, "R6 done from last release", dK, RECOVER + 3);
    drove = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (busyLineDriveLow || !accessAllowed) drove++;
    end
    check(drove == 0, "R8 request ignored", drove, 0);

    // R10 write in flight at end of store
    chipEnN = 1'b0; writeEnN = 1'b0;
    hostStore(1, 2, 1'b1, pLen, eK, dK, aBad);
    check(dK == 1 + 2 + 3 + RECOVER, "R10 store completes", dK, 1 + 2 + 3 + RECOVER);
    check(accessAllowed && !writeAllowed, "R10 write blocked at done", writeAllowed, 0);
    @(negedge clk) writeEnN = 1'b1;
    @(negedge clk);
    check(!writeAllowed, "R10 rising strobe keeps block", writeAllowed, 0);
    writeEnN = 1'b0;
    @(negedge clk);
    check(writeAllowed, "R10 falling strobe clears block", writeAllowed, 1);

    // R10 no write in flight: write follows access
    chipEnN = 1'b1; writeEnN = 1'b0;
    hostStore(0, 1, 1'b1, pLen, eK, dK, aBad);
    check(writeAllowed == accessAllowed && writeAllowed, "R10 write follows access",
          writeAllowed, 1);
    writeEnN = 1'b1;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule